// File: doc/BRIEF.md
# DMA Command-Queue Register Interface

This block is the software-facing control front end of a host-to-device DMA engine. It holds a bank of 32-bit words reached over a simple synchronous register bus with word-only accesses. Among them are the command-queue base, end, write and read pointers, an interrupt control word and an interrupt status word. Data movement itself is not modelled. Each update of the write pointer counts as a transfer that completes at once: the read pointer catches up with the write pointer, and both completion bits in the status word are raised.

Software can suppress the next completion in advance. It does this by writing a fixed key value to the read-pointer offset. That write does not change the stored read pointer. It only arms a one-shot skip, and the skip is used up by the next write-pointer update. The single interrupt output is a registered level. It rises on a completion while either completion enable is set, and it stays high until software acknowledges the status.

The bus decodes a 0x1000-byte window. The 32 words at 0x00-0x7C are backed by storage. Other offsets read as zero and ignore writes. A read returns its data on `bus_rdata` in the cycle after the read strobe, and the value is held until the next read.

Top module: `dma_cmdq_regs`

## Requirements
- R1: After reset every word reads as zero, except the status word at 0x24, which reads 0xF8000000. The interrupt output is low and the one-shot skip is disarmed.
- R2: Writes to the end pointer (0x14) and the write pointer (0x18) keep only bits [17:0]. Bits [31:18] read back as zero.
- R3: A write to the write pointer also loads the same masked value into the read pointer (0x1C).
- R4: A bus write to the read pointer never changes its stored value, whatever the data.
- R5: Writing exactly 0xEE882266 to 0x1C arms a one-shot skip. The next write-pointer write then signals no completion (status and interrupt unchanged) and disarms the skip. Later write-pointer writes complete normally.
- R6: A write-pointer write with the skip disarmed sets status bits 4 and 5. In the next cycle the interrupt goes high if control bit 4 or control bit 5 is set.
- R7: Writes to the control word (0x20) are ANDed with 0xBFEFF07F before storage.
- R8: A status write with bit 4 or bit 5 set clears both bits 4 and 5 and drives the interrupt low in the next cycle.
- R9: Status bits other than 4 and 5 cannot be written. They always read as 0xF8000000.
- R10: Reads of offsets 0x80-0xFFF return zero, and writes to them change no word.
- R11: The interrupt is a held level. A change to the control word neither raises nor lowers it.
- R12: All other offsets in 0x00-0x7C are plain 32-bit read/write storage. Address bits [1:0] are ignored, and read data appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Level interrupt for completion |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that both are low during reset. Under that assumption, a rising interrupt can only follow a write to the write-pointer offset, and read data can be tied to the strobe one cycle earlier. The bench issues one operation at a time through tasks that raise exactly one strobe for a single cycle. Its random addresses cover the special words, the rest of the array and the unbacked part of the window.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 32;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  // word indices whose behaviour is special
  localparam int IDX_END   = 5;
  localparam int IDX_WPTR  = 6;
  localparam int IDX_RPTR  = 7;
  localparam int IDX_CTRL  = 8;
  localparam int IDX_STAT  = 9;

  localparam logic [DATA_W-1:0] PTR_MASK   = 32'h0003_FFFF;
  localparam logic [DATA_W-1:0] CTRL_MASK  = 32'hBFEF_F07F;
  localparam logic [DATA_W-1:0] STAT_FIXED = 32'hF800_0000;
  localparam logic [DATA_W-1:0] SKIP_KEY   = 32'hEE88_2266;
  localparam int DONE_UP   = 4;
  localparam int DONE_DOWN = 5;

  typedef struct packed {
    logic             store;     // plain or masked store into idx
    logic             wptr_upd;  // write-pointer update event
    logic [IDX_W-1:0] idx;
  } wr_cmd_t;

  function automatic logic [DATA_W-1:0] store_mask(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      IDX_END, IDX_WPTR: store_mask = PTR_MASK;
      IDX_CTRL:          store_mask = CTRL_MASK;
      default:           store_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/dcq_decode.sv
module dcq_decode
  import dcq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output wr_cmd_t           cmd,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx,
  output logic              skip_arm,
  output logic              ack_clear
);
  localparam int HI_LSB = IDX_W + 2;

  logic unused_low;
  logic wr_ok;

  assign unused_low = ^bus_addr[1:0];
  assign in_range   = (bus_addr[ADDR_W-1:HI_LSB] == '0);
  assign idx        = bus_addr[HI_LSB-1:2];
  assign wr_ok      = bus_wr && in_range;

  always_comb begin
    cmd.idx      = idx;
    cmd.wptr_upd = wr_ok && (int'(idx) == IDX_WPTR);
    cmd.store    = wr_ok && (int'(idx) != IDX_RPTR) && (int'(idx) != IDX_STAT);
  end

  assign skip_arm  = wr_ok && (int'(idx) == IDX_RPTR) && (bus_wdata == SKIP_KEY);
  assign ack_clear = wr_ok && (int'(idx) == IDX_STAT) &&
                     (bus_wdata[DONE_UP] || bus_wdata[DONE_DOWN]);
endmodule

// File: rtl/dcq_regfile.sv
module dcq_regfile
  import dcq_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  wr_cmd_t                           cmd,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [DATA_W-1:0]                 status_word,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);
  logic [DATA_W-1:0] masked;
  assign masked = wdata & store_mask(cmd.idx);

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == IDX_STAT) begin : g_stat
      assign words[i] = status_word;
    end else if (i == IDX_RPTR) begin : g_rptr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            words[i] <= '0;
        else if (cmd.wptr_upd) words[i] <= wdata & PTR_MASK;
      end
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  words[i] <= '0;
        else if (cmd.store && (int'(cmd.idx) == i))  words[i] <= masked;
      end
    end
  end
endmodule

// File: rtl/dcq_event.sv
module dcq_event
  import dcq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wptr_upd,
  input  logic              skip_arm,
  input  logic              ack_clear,
  input  logic              irq_en,
  output logic              skip_armed,
  output logic              done,
  output logic              irq,
  output logic [DATA_W-1:0] status_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_armed <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (skip_arm) skip_armed <= 1'b1;
      if (wptr_upd) begin
        if (skip_armed) begin
          skip_armed <= 1'b0;
        end else begin
          done <= 1'b1;
          if (irq_en) irq <= 1'b1;
        end
      end
      if (ack_clear) begin
        done <= 1'b0;
        irq  <= 1'b0;
      end
    end
  end

  always_comb begin
    status_word = STAT_FIXED;
    status_word[DONE_UP]   = done;
    status_word[DONE_DOWN] = done;
  end
endmodule

// File: rtl/dma_cmdq_regs.sv
module dma_cmdq_regs
  import dcq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  wr_cmd_t                         cmd;
  logic                            in_range;
  logic [IDX_W-1:0]                idx;
  logic                            skip_arm, ack_clear;
  logic                            skip_armed, done;
  logic [DATA_W-1:0]               status_word;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic                            irq_en;

  dcq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .cmd      (cmd),
    .in_range (in_range),
    .idx      (idx),
    .skip_arm (skip_arm),
    .ack_clear(ack_clear)
  );

  dcq_regfile u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .wdata      (bus_wdata),
    .status_word(status_word),
    .words      (words)
  );

  assign irq_en = words[IDX_CTRL][DONE_UP] || words[IDX_CTRL][DONE_DOWN];

  dcq_event u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wptr_upd   (cmd.wptr_upd),
    .skip_arm   (skip_arm),
    .ack_clear  (ack_clear),
    .irq_en     (irq_en),
    .skip_armed (skip_armed),
    .done       (done),
    .irq        (irq_out),
    .status_word(status_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= in_range ? words[idx] : '0;
  end
endmodule

// File: rtl/dcq_regs_chk.sv
module dcq_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_out
);
  logic [ADDR_W-3:0] wa;
  logic              oor;
  assign wa  = bus_addr[ADDR_W-1:2];
  assign oor = (bus_addr[ADDR_W-1:7] != '0);

  AST_END_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (wa == (ADDR_W-2)'(5)) |=> bus_rdata[31:18] == '0); // R2

  AST_STAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (wa == (ADDR_W-2)'(9)) |=> (bus_rdata & 32'hFFFF_FFCF) == 32'hF800_0000); // R9

  AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(bus_wr) && ($past(wa) == (ADDR_W-2)'(6))); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (wa == (ADDR_W-2)'(9)) && (bus_wdata[5] || bus_wdata[4]) |=> !irq_out); // R8

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && oor |=> bus_rdata == '0); // R10

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (wa == (ADDR_W-2)'(8)) |=> $stable(irq_out)); // R11
endmodule

bind dma_cmdq_regs dcq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
);

// File: tb/dma_cmdq_regs_test.sv
module dma_cmdq_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam logic [31:0] KEY = 32'hEE88_2266;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cmdq_regs #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  int checks = 0, errors = 0;
  logic [31:0] m_reg [32];
  bit m_skip = 0, m_done = 0, m_irq = 0;

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:7] != 0) return 32'h0;
    if (a[6:2] == 5'd9) return 32'hF800_0000 | (m_done ? 32'h30 : 32'h0);
    return m_reg[a[6:2]];
  endfunction

  function automatic string tag_for(logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:7] != 0) return "R10";
    case (a[6:2])
      5'd5, 5'd6: return "R2";
      5'd7:       return "R3";
      5'd8:       return "R7";
      5'd9:       return "R9";
      default:    return "R12";
    endcase
  endfunction

  function automatic void model_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    if (a[ADDR_W-1:7] != 0) return;
    case (a[6:2])
      5'd5: m_reg[5] = d & 32'h0003_FFFF;
      5'd6: begin
        m_reg[6] = d & 32'h0003_FFFF;
        m_reg[7] = m_reg[6];
        if (m_skip) m_skip = 0;
        else begin
          m_done = 1;
          if (m_reg[8][4] || m_reg[8][5]) m_irq = 1;
        end
      end
      5'd7: if (d == KEY) m_skip = 1;
      5'd8: m_reg[8] = d & 32'hBFEF_F07F;
      5'd9: if (d[4] || d[5]) begin m_done = 0; m_irq = 0; end
      default: m_reg[a[6:2]] = d;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, string itag = "R6");
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
    check(itag, {31'b0, irq_out}, {31'b0, m_irq});
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, string tag = "");
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(tag == "" ? tag_for(a) : tag, bus_rdata, exp_read(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, irq_out}, 32'h0);
    rst_n = 1;
    for (int i = 0; i < 32; i++) rd(ADDR_W'(i * 4), "R1");
    rd(12'h080, "R1");

    // directed corners
    wr(12'h014, 32'hFFFF_FFFF); rd(12'h014, "R2");
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, "R7");       // enables on
    wr(12'h018, 32'hABCD_1234, "R6"); rd(12'h018, "R2"); rd(12'h01C, "R3");
    rd(12'h024, "R6");
    wr(12'h01C, 32'h1234_5678); rd(12'h01C, "R4");
    wr(12'h024, 32'h0000_0010, "R8"); rd(12'h024, "R8");
    wr(12'h01C, KEY); rd(12'h01C, "R4");
    wr(12'h018, 32'h0000_0055, "R5"); rd(12'h024, "R5"); rd(12'h01C, "R3");
    wr(12'h018, 32'h0000_0066, "R5"); rd(12'h024, "R5");
    wr(12'h020, 32'h0, "R11");                           // irq stays up
    wr(12'h024, 32'h0000_0020, "R8");
    wr(12'h018, 32'h0000_0001, "R6");                    // no enables -> no irq
    wr(12'h020, 32'h0000_0030, "R11");                   // enabling does not raise
    wr(12'h024, 32'h07FF_FFCF, "R9"); rd(12'h024, "R9");
    wr(12'h024, 32'h0000_0030, "R8");
    wr(12'h004, 32'hCAFE_F00D); wr(12'h084, 32'h1111_1111); rd(12'h004, "R10");
    wr(12'hFFC, 32'h2222_2222); rd(12'hFFC, "R10");
    wr(12'h043, 32'h5A5A_A5A5); rd(12'h040, "R12"); rd(12'h042, "R12");

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      int sel = $urandom % 10;
      if (sel < 6)      a = ADDR_W'((16 + ($urandom % 6) * 4) | ($urandom % 4));
      else if (sel < 9) a = ADDR_W'(($urandom % 32) * 4);
      else              a = ADDR_W'(12'h080 + ($urandom % 12'hF80));
      d = $urandom;
      if ($urandom % 6 == 0) d = KEY;
      else if ($urandom % 5 == 0) d = ($urandom % 2) ? 32'h10 : 32'h20;
      if ($urandom % 2) wr(a, d);
      else rd(a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule